// File: doc/BRIEF.md
# Tone Burst Transmit Sequencer

This block times the transmit side of a dual-tone signalling transceiver. A host stores a 4-bit tone code into the transmit register. The block passes that code to a downstream tone generator, together with a mode field that selects a dual tone, a single row tone or a single column tone. The block does not synthesise any tones itself. It also asserts a tone-enable output that tells the generator when to sound.

In burst mode, a write starts a timed sequence. The tone sounds for a fixed number of ticks, then stays silent for the same number of ticks. At the end of the silence the block pulses a ready event, which the status logic uses to mark the transmit register empty. A call-progress option doubles both intervals. Time is counted in ticks of an external 1 kHz strobe. With burst mode off, the tone simply follows a host tone-out bit. A separate output requests power-down of the oscillator and reference circuits when the transmitter and the receiver are both idle.

Top module: `tone_burst_seq`

## Requirements
- R1: After reset, code_o is 0, mode_o is 2'b00, ready_o is 0 and power_down_o is 0. tone_en_o is 0 while tone_out_i is low.
- R2: Burst mode is active when burst_n_i is 0. In that mode, a write (wr_i high) while idle latches wr_code_i onto code_o at that clock edge. tone_en_o is then high for exactly 51 ticks, starting in the cycle after the write.
- R3: When the burst ends, tone_en_o stays low for a pause of the same tick count as the burst. ready_o is high for exactly one cycle, in the cycle after the tick that ends the pause.
- R4: cp_mode_i is sampled at the write that starts a sequence. If it is 1, both the burst and the pause last 102 ticks. A change of cp_mode_i during a sequence has no effect on that sequence.
- R5: A write during a burst or a pause is ignored. code_o keeps the code it latched at the start, and the sequence timing is unchanged.
- R6: While burst_n_i is 1, tone_en_o equals tone_out_i. A write latches its code at once, and ready_o stays 0.
- R7: If burst_n_i rises during a sequence, the sequence is abandoned: no ready_o pulse follows. A later write in burst mode starts a new sequence.
- R8: mode_o is registered one cycle after single_i and col_i. Bit 1 is 1 for a single tone. Bit 0 is 1 for a column tone, and is forced to 0 when bit 1 is 0. The value 2'b01 never appears.
- R9: power_down_o is registered one cycle after its inputs. It is 1 exactly when rx_off_i is 1 and tone_out_i is 0.
- R10: Durations are counted in tick_i pulses, not in clock cycles. With a tick every 3 cycles, a 51-tick burst lasts between 151 and 153 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 1 kHz strobe, one cycle wide |
| burst_n_i | input | 1 | 0 = burst mode, 1 = direct tone control |
| cp_mode_i | input | 1 | Call-progress mode: doubles the burst and pause lengths |
| tone_out_i | input | 1 | Tone-out bit from the host, used outside burst mode |
| rx_off_i | input | 1 | Receiver power-down control |
| single_i | input | 1 | 1 = single tone, 0 = dual tone |
| col_i | input | 1 | 1 = column tone, 0 = row tone (single-tone mode only) |
| wr_i | input | 1 | Write strobe for the transmit register |
| wr_code_i | input | 4 | Tone code to write |
| tone_en_o | output | 1 | Tone enable to the generator |
| code_o | output | 4 | Latched tone code |
| mode_o | output | 2 | Tone mode: bit 1 = single, bit 0 = column |
| ready_o | output | 1 | One-cycle pulse at the end of the pause |
| power_down_o | output | 1 | Power-down request for the oscillator and reference circuits |

## Verification
The assertions assume the following about the inputs:
- Inputs change only between clock edges.
- burst_n_i is held long enough that any cycle with a ready pulse also had burst mode in the cycle before it.
- After burst_n_i has been high for a full cycle, the sequencer has returned to idle.

The stimulus meets these assumptions:
- It drives every input on the falling clock edge.
- It leaves burst_n_i low for the whole of each timed sequence, except in the one test that abandons a sequence on purpose.
- That test holds burst_n_i high for several cycles before it re-enters burst mode.

// File: rtl/tbs_pkg.sv
package tbs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BURST = 2'd1,
    ST_PAUSE = 2'd2
  } seq_st_e;

  typedef enum logic [1:0] {
    MODE_DUAL = 2'b00,
    MODE_ROW  = 2'b10,
    MODE_COL  = 2'b11
  } tone_mode_e;
endpackage

// File: rtl/tbs_tick_timer.sv
module tbs_tick_timer #(
  parameter int CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  assign done_o = !clear_i && tick_i && (cnt_q == limit_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clear_i || done_o)  cnt_q <= '0;
    else if (tick_i)             cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/tbs_code_reg.sv
module tbs_code_reg #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/tbs_seq_fsm.sv
module tbs_seq_fsm
  import tbs_pkg::*;
#(
  parameter int TICKS_BASE = 51,
  parameter int TICKS_CP   = 102,
  parameter int CNT_W      = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             burst_en_i,
  input  logic             start_i,
  input  logic             cp_i,
  input  logic             done_i,
  output seq_st_e          st_o,
  output logic             clear_o,
  output logic [CNT_W-1:0] limit_o,
  output logic             ready_o
);
  seq_st_e st_q, st_d;
  logic    cp_q;

  always_comb begin
    st_d = st_q;
    if (!burst_en_i) st_d = ST_IDLE;
    else begin
      unique case (st_q)
        ST_IDLE:  if (start_i) st_d = ST_BURST;
        ST_BURST: if (done_i)  st_d = ST_PAUSE;
        ST_PAUSE: if (done_i)  st_d = ST_IDLE;
        default:               st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cp_q    <= 1'b0;
      ready_o <= 1'b0;
    end else begin
      st_q    <= st_d;
      ready_o <= burst_en_i && (st_q == ST_PAUSE) && done_i;
      // call-progress length is frozen at sequence start
      if (st_q == ST_IDLE && start_i) cp_q <= cp_i;
    end
  end

  assign st_o    = st_q;
  assign clear_o = (st_q == ST_IDLE);
  assign limit_o = cp_q ? CNT_W'(TICKS_CP) : CNT_W'(TICKS_BASE);
endmodule

// File: rtl/tone_burst_seq.sv
module tone_burst_seq
  import tbs_pkg::*;
#(
  parameter int CODE_W     = 4,
  parameter int TICKS_BASE = 51,
  parameter int TICKS_CP   = 102
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              burst_n_i,
  input  logic              cp_mode_i,
  input  logic              tone_out_i,
  input  logic              rx_off_i,
  input  logic              single_i,
  input  logic              col_i,
  input  logic              wr_i,
  input  logic [CODE_W-1:0] wr_code_i,
  output logic              tone_en_o,
  output logic [CODE_W-1:0] code_o,
  output logic [1:0]        mode_o,
  output logic              ready_o,
  output logic              power_down_o
);
  localparam int CNT_W = $clog2(TICKS_CP + 1);

  seq_st_e          st;
  logic             clear, done, accept, burst_en;
  logic [CNT_W-1:0] limit;
  tone_mode_e       mode_q;

  assign burst_en = !burst_n_i;
  assign accept   = wr_i && (st == ST_IDLE);

  tbs_code_reg #(.W(CODE_W)) u_code (
    .clk_i, .rst_ni, .load_i(accept), .d_i(wr_code_i), .q_o(code_o)
  );

  tbs_seq_fsm #(
    .TICKS_BASE(TICKS_BASE), .TICKS_CP(TICKS_CP), .CNT_W(CNT_W)
  ) u_fsm (
    .clk_i, .rst_ni, .burst_en_i(burst_en), .start_i(accept && burst_en),
    .cp_i(cp_mode_i), .done_i(done), .st_o(st), .clear_o(clear),
    .limit_o(limit), .ready_o(ready_o)
  );

  tbs_tick_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i, .rst_ni, .clear_i(clear), .tick_i(tick_i), .limit_i(limit), .done_o(done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q       <= MODE_DUAL;
      power_down_o <= 1'b0;
    end else begin
      mode_q       <= !single_i ? MODE_DUAL : (col_i ? MODE_COL : MODE_ROW);
      power_down_o <= rx_off_i && !tone_out_i;
    end
  end

  assign mode_o    = mode_q;
  assign tone_en_o = (st == ST_BURST) || (burst_n_i && tone_out_i);
endmodule

// File: rtl/tone_burst_seq_chk.sv
module tone_burst_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       burst_n_i,
  input logic       tone_out_i,
  input logic       rx_off_i,
  input logic       tone_en_o,
  input logic [3:0] code_o,
  input logic [1:0] mode_o,
  input logic       ready_o,
  input logic       power_down_o
);
  // R3
  ready_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);

  // R3
  ready_after_silence_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !$past(tone_en_o));

  // R7
  ready_needs_burst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !$past(burst_n_i));

  // R5
  code_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tone_en_o && $past(tone_en_o) && !burst_n_i && !$past(burst_n_i)) |-> $stable(code_o));

  // R6
  direct_tone_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (burst_n_i && $past(burst_n_i)) |-> (tone_en_o == tone_out_i));

  // R8
  mode_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 2'b01);

  // R9
  pd_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    power_down_o |-> ($past(rx_off_i) && !$past(tone_out_i)));
endmodule

bind tone_burst_seq tone_burst_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .burst_n_i(burst_n_i), .tone_out_i(tone_out_i),
  .rx_off_i(rx_off_i), .tone_en_o(tone_en_o), .code_o(code_o), .mode_o(mode_o),
  .ready_o(ready_o), .power_down_o(power_down_o)
);

// File: tb/tb_tone_burst_seq.sv
module tb_tone_burst_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, burst_n = 1'b0, cp_mode = 1'b0, tone_out = 1'b0, rx_off = 1'b0;
  logic single = 1'b0, col = 1'b0, wr = 1'b0;
  logic [3:0] wr_code = '0;
  logic tone_en, ready, pd;
  logic [3:0] code;
  logic [1:0] mode;
  int checks = 0, errors = 0;
  int tick_per = 1, tick_cnt = 0;

  always #4 clk = ~clk;

  tone_burst_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .burst_n_i(burst_n), .cp_mode_i(cp_mode),
    .tone_out_i(tone_out), .rx_off_i(rx_off), .single_i(single), .col_i(col), .wr_i(wr),
    .wr_code_i(wr_code), .tone_en_o(tone_en), .code_o(code), .mode_o(mode),
    .ready_o(ready), .power_down_o(pd)
  );

  always @(negedge clk) begin
    if (tick_cnt + 1 >= tick_per) begin tick <= 1'b1; tick_cnt <= 0; end
    else begin tick <= 1'b0; tick_cnt <= tick_cnt + 1; end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // {single, col, tone_out, rx_off, mode[1:0], pd, tone_en}, burst mode off
  localparam logic [7:0] VEC [8] = '{
    8'b0000_0000, 8'b0011_0001, 8'b1001_1010, 8'b1101_1110,
    8'b1111_1101, 8'b0001_0010, 8'b1010_1001, 8'b0101_0010
  };

  // write, then measure tone-high and tone-low cycles until ready; poke writes inside
  task automatic burst_run(input logic [3:0] c, input logic cp, input int poke,
                           output int hi, output int lo);
    @(negedge clk); wr = 1'b1; wr_code = c; cp_mode = cp;
    @(negedge clk); wr = 1'b0; cp_mode = ~cp;
    hi = 0; lo = 0;
    while (tone_en && hi < 2000) begin
      hi++;
      wr = (hi == poke); wr_code = ~c;
      @(negedge clk);
    end
    wr = 1'b0;
    while (!ready && lo < 2000) begin
      lo++;
      wr = (lo == poke); wr_code = ~c;
      @(negedge clk);
    end
    wr = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int hi, lo;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 code", code, 0); chk("R1 mode", mode, 0); chk("R1 ready", ready, 0);
    chk("R1 pd", pd, 0); chk("R1 tone", tone_en, 0);

    // R6 R8 R9 vector walk in direct mode
    burst_n = 1'b1;
    foreach (VEC[i]) begin
      @(negedge clk);
      {single, col, tone_out, rx_off} = VEC[i][7:4];
      wr = 1'b1; wr_code = 4'(i + 3);
      @(negedge clk); wr = 1'b0;
      chk("R8 mode", mode, VEC[i][3:2]);
      chk("R9 pd", pd, VEC[i][1]);
      chk("R6 tone", tone_en, VEC[i][0]);
      chk("R6 code", code, i + 3);
      chk("R6 ready", ready, 0);
    end
    tone_out = 1'b0; rx_off = 1'b0; single = 1'b0; col = 1'b0;
    burst_n = 1'b0;
    @(negedge clk);

    // R2 R3 base burst
    burst_run(4'h5, 1'b0, 0, hi, lo);
    chk("R2 burst len", hi, 51); chk("R3 pause len", lo, 51);
    chk("R3 ready", ready, 1); chk("R2 code", code, 5);
    @(negedge clk); chk("R3 ready one cycle", ready, 0);

    // R4 call-progress doubling, cp toggled mid-sequence
    burst_run(4'hA, 1'b1, 0, hi, lo);
    chk("R4 burst len", hi, 102); chk("R4 pause len", lo, 102); chk("R4 ready", ready, 1);

    // R5 writes during burst and pause ignored
    burst_run(4'h3, 1'b0, 20, hi, lo);
    chk("R5 burst len", hi, 51); chk("R5 pause len", lo, 51); chk("R5 code", code, 3);

    // R10 slower ticks
    tick_per = 3;
    burst_run(4'h9, 1'b0, 0, hi, lo);
    chk("R10 burst min", int'(hi >= 151), 1); chk("R10 burst max", int'(hi <= 153), 1);
    tick_per = 1;

    // R7 abandon mid-burst
    @(negedge clk); wr = 1'b1; wr_code = 4'h6;
    @(negedge clk); wr = 1'b0;
    repeat (10) @(negedge clk);
    burst_n = 1'b1;
    @(negedge clk); chk("R7 tone off", tone_en, 0);
    repeat (4) @(negedge clk);
    burst_n = 1'b0;
    begin
      int seen = 0;
      for (int k = 0; k < 120; k++) begin @(negedge clk); seen += int'(ready); end
      chk("R7 no ready", seen, 0);
    end
    burst_run(4'hC, 1'b0, 0, hi, lo);
    chk("R7 restart code", code, 12); chk("R7 restart len", hi, 51);

    // R1 asynchronous reset mid-burst
    @(negedge clk); wr = 1'b1; wr_code = 4'h7;
    @(negedge clk); wr = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0; #1;
    chk("R1 reset tone", tone_en, 0); chk("R1 reset code", code, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); chk("R1 reset ready", ready, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule